// File: doc/BRIEF.md
# Single-Descriptor Word Copy Engine

This block is a one-channel DMA engine that moves 32-bit words from a source address to a destination address over a simple request/acknowledge bus master port. It holds one descriptor: source address, destination address, word count, and an address mode for each side. Each side's mode is either held or stepping by 4. Software writes the descriptor into a small register file and starts the engine by writing a start bit. The descriptor is copied into a working copy, so later register writes do not disturb the transfer in progress.

Each word takes one read and then one write. Every access keeps its request up until the slave acknowledges. A peripheral that has no data yet can therefore stall the copy for as long as it needs. A typical use drains a peripheral data register into a memory buffer: the source address is held and the destination steps. A sector of 512 bytes is 128 words.

A programmable acknowledge limit can end a hung access with an error flag. When the last word has been written, a done flag is set, and it drives a level interrupt until software clears it.

Top module: `copy_dma`

## Requirements
- R1: After reset there is no bus request and `irq` is low. Register 4 (status) reads 0, register 5 (ack limit) reads 1024, and register 0 (source) reads 0.
- R2: A write to register 3 (control) with bit 0 set, made while the engine is idle and the count (register 2) is nonzero, starts a transfer. Each word is one read (`bus_we`=0) at the current source address, followed by one write (`bus_we`=1) of the returned data to the current destination address (register 1).
- R3: While `bus_ack` is low, `bus_req`, `bus_addr`, `bus_we` and `bus_wdata` hold their values, for any number of stall cycles.
- R4: Control bit 1 set makes the source address step by 4 after each word; with it clear, every read uses the same source address.
- R5: Control bit 2 set makes the destination address step by 4 after each word; with it clear, every write goes to the same destination address.
- R6: After exactly the programmed number of words (128 included), the done flag (status bit 1) is set on the edge that takes the final write acknowledge. The bus request then drops.
- R7: `irq` follows the done flag. It stays high until software writes status with bit 1 set.
- R8: A start written while status bit 0 (busy) reads 1 is dropped. The running transfer keeps its addresses, and no further transfer follows it.
- R9: A start with a count of 0 sets the done flag without any bus request.
- R10: With a nonzero limit L, an access left unacknowledged for L consecutive request cycles is abandoned. The request drops, status bit 2 (error) is set and done is not set. Writing status with bit 2 set clears the error. A limit of 0 lets an access wait without bound.
- R11: Status bit 0 reads 1 from the cycle after an accepted start until the transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 src, 1 dst, 2 count, 3 control, 4 status, 5 limit) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| bus_req | output | 1 | Bus access request, held until acknowledged |
| bus_we | output | 1 | 1 for a write access, 0 for a read |
| bus_addr | output | 32 | Byte address of the access |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Slave acknowledge, completes the access in this cycle |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` on a read |
| irq | output | 1 | Level completion interrupt |

## Verification
The hardest situations to reach from the ports are the abandoned access and the start that arrives mid-transfer. Both depend on what the slave does on the far side of the handshake, not on register writes alone. The bench's slave model can therefore add a set number of wait cycles or withhold the acknowledge entirely. Withholding it runs the limit counter to expiry, and an unbounded stall with the limit at 0 must still complete. The model also returns a running sequence from one fixed peripheral address, so a held source draining into a stepping buffer shows any skipped or repeated word. A 128-word transfer with wait states keeps the engine busy long enough for a second start and new descriptor writes to arrive while it runs.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int REG_W  = 3;
    localparam int STEP   = 4;

    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} seq_state_e;

    typedef enum logic [REG_W-1:0] {
        RA_SRC   = 3'd0,
        RA_DST   = 3'd1,
        RA_CNT   = 3'd2,
        RA_CTRL  = 3'd3,
        RA_STAT  = 3'd4,
        RA_LIMIT = 3'd5
    } reg_addr_e;

    localparam int CTRL_GO   = 0;
    localparam int CTRL_SINC = 1;
    localparam int CTRL_DINC = 2;
    localparam int STAT_BUSY = 0;
    localparam int STAT_DONE = 1;
    localparam int STAT_ERR  = 2;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic              src_inc;
        logic              dst_inc;
    } desc_t;

    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a, input logic inc);
        return inc ? a + ADDR_W'(STEP) : a;
    endfunction
endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int TMO_W     = 16,
    parameter int DEF_LIMIT = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              seq_busy,
    input  logic              fin_ok,
    input  logic              fin_err,
    output desc_t             desc,
    output logic [CNT_W-1:0]  cnt,
    output logic [TMO_W-1:0]  limit,
    output logic              go_q,
    output logic              done_q,
    output logic              err_q,
    output logic              clr_done
);
    logic wr_ctrl, wr_stat, clr_err, busy_all;

    assign wr_ctrl  = we && (addr == RA_CTRL);
    assign wr_stat  = we && (addr == RA_STAT);
    assign clr_done = wr_stat && wdata[STAT_DONE];
    assign clr_err  = wr_stat && wdata[STAT_ERR];
    assign busy_all = seq_busy || go_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            desc   <= '0;
            cnt    <= '0;
            limit  <= TMO_W'(DEF_LIMIT);
            go_q   <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            go_q <= wr_ctrl && wdata[CTRL_GO] && !busy_all;
            if (we) begin
                case (addr)
                    RA_SRC:   desc.src <= wdata;
                    RA_DST:   desc.dst <= wdata;
                    RA_CNT:   cnt      <= wdata[CNT_W-1:0];
                    RA_CTRL: begin
                        desc.src_inc <= wdata[CTRL_SINC];
                        desc.dst_inc <= wdata[CTRL_DINC];
                    end
                    RA_LIMIT: limit    <= wdata[TMO_W-1:0];
                    default:  ;
                endcase
            end
            if (fin_ok)        done_q <= 1'b1;
            else if (clr_done) done_q <= 1'b0;
            if (fin_err)       err_q  <= 1'b1;
            else if (clr_err)  err_q  <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RA_SRC:   rdata = desc.src;
            RA_DST:   rdata = desc.dst;
            RA_CNT:   rdata = DATA_W'(cnt);
            RA_CTRL: begin
                rdata[CTRL_SINC] = desc.src_inc;
                rdata[CTRL_DINC] = desc.dst_inc;
            end
            RA_STAT: begin
                rdata[STAT_BUSY] = busy_all;
                rdata[STAT_DONE] = done_q;
                rdata[STAT_ERR]  = err_q;
            end
            RA_LIMIT: rdata = DATA_W'(limit);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_wdog.sv
module dma_wdog #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             ack,
    input  logic [TMO_W-1:0] limit,
    output logic             expire
);
    logic [TMO_W-1:0] wait_q;

    always_ff @(posedge clk) begin
        if (rst || !req || ack) wait_q <= '0;
        else                    wait_q <= wait_q + 1'b1;
    end

    // limit of zero never expires
    assign expire = req && !ack && (limit != '0) && (wait_q == limit - 1'b1);
endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  desc_t             desc,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              abort,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              busy,
    output logic              fin_ok
);
    seq_state_e        st_q;
    desc_t             work_q;
    logic [DATA_W-1:0] data_q;
    logic [CNT_W-1:0]  rem_q;
    logic              last_word;

    assign last_word = (rem_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            work_q <= '0;
            data_q <= '0;
            rem_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (start && cnt != '0) begin
                    work_q <= desc;
                    rem_q  <= cnt;
                    st_q   <= ST_READ;
                end
                ST_READ: if (bus_ack) begin
                    data_q <= bus_rdata;
                    st_q   <= ST_WRITE;
                end else if (abort) begin
                    st_q   <= ST_IDLE;
                end
                ST_WRITE: if (bus_ack) begin
                    work_q.src <= step_addr(work_q.src, work_q.src_inc);
                    work_q.dst <= step_addr(work_q.dst, work_q.dst_inc);
                    rem_q      <= rem_q - 1'b1;
                    st_q       <= last_word ? ST_IDLE : ST_READ;
                end else if (abort) begin
                    st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign bus_req   = (st_q != ST_IDLE);
    assign bus_we    = (st_q == ST_WRITE);
    assign bus_addr  = (st_q == ST_WRITE) ? work_q.dst : work_q.src;
    assign bus_wdata = data_q;
    assign busy      = (st_q != ST_IDLE);
    assign fin_ok    = (st_q == ST_IDLE && start && cnt == '0) ||
                       (st_q == ST_WRITE && bus_ack && last_word);
endmodule

// File: rtl/copy_dma.sv
module copy_dma
    import dma_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int TMO_W     = 16,
    parameter int DEF_LIMIT = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    desc_t            desc;
    logic [CNT_W-1:0] cnt_val;
    logic [TMO_W-1:0] limit;
    logic             go_q, done_flag, err_flag, clr_done;
    logic             seq_busy, fin_ok, expire;

    dma_regs #(.CNT_W(CNT_W), .TMO_W(TMO_W), .DEF_LIMIT(DEF_LIMIT)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .seq_busy(seq_busy), .fin_ok(fin_ok), .fin_err(expire),
        .desc(desc), .cnt(cnt_val), .limit(limit), .go_q(go_q),
        .done_q(done_flag), .err_q(err_flag), .clr_done(clr_done)
    );

    dma_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .start(go_q), .desc(desc), .cnt(cnt_val),
        .abort(expire), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .busy(seq_busy), .fin_ok(fin_ok)
    );

    dma_wdog #(.TMO_W(TMO_W)) u_wdog (
        .clk(clk), .rst(rst), .req(bus_req), .ack(bus_ack), .limit(limit),
        .expire(expire)
    );

    assign irq = done_flag;
endmodule

// File: rtl/dma_chk.sv
module dma_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_req,
    input logic             bus_we,
    input logic             bus_ack,
    input logic [31:0]      bus_addr,
    input logic             irq,
    input logic             seq_busy,
    input logic             err_flag,
    input logic             go_q,
    input logic [CNT_W-1:0] cnt_val,
    input logic             clr_done
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !bus_req && !irq);

    // R3
    hold_req_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> !bus_req || ($stable(bus_addr) && $stable(bus_we)));

    // R10
    drop_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_req) |-> $past(bus_ack) || err_flag);

    // R2
    first_read_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_busy) |-> bus_req && !bus_we);

    // R2
    read_then_write_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_ack && !bus_we |=> bus_req && bus_we);

    // R9
    zero_count_chk: assert property (@(posedge clk) disable iff (rst)
        go_q && !seq_busy && cnt_val == '0 |=> irq && !bus_req);

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        irq && !clr_done |=> irq);
endmodule

bind copy_dma dma_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_ack(bus_ack),
    .bus_addr(bus_addr), .irq(irq), .seq_busy(seq_busy), .err_flag(err_flag),
    .go_q(go_q), .cnt_val(cnt_val), .clr_done(clr_done)
);

// File: tb/sim_copy_dma.sv
module sim_copy_dma;
    localparam logic [31:0] PERIPH = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        bus_req, bus_we, irq;
    logic [31:0] bus_addr, bus_wdata;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = 32'd0;

    always #10 clk = ~clk;

    copy_dma u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .irq(irq)
    );

    int checks = 0, errors = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // slave model
    logic [31:0] mem [logic [31:0]];
    int  lat = 0, stall = 0, nrd = 0, nwr = 0, run = 0, last_run = 0;
    bit  hang = 0;
    logic [31:0] pnext = 32'hC0DE_0000;

    always @(negedge clk) begin
        if (bus_req) run++;
        else begin
            if (run > 0) last_run = run;
            run = 0;
        end
        if (bus_req && !hang && stall >= lat) begin
            bus_ack = 1'b1;
            stall = 0;
            if (bus_we) begin
                mem[bus_addr] = bus_wdata;
                nwr++;
            end else begin
                nrd++;
                if (bus_addr == PERIPH) begin
                    bus_rdata = pnext;
                    pnext = pnext + 32'd1;
                end else bus_rdata = mem.exists(bus_addr) ? mem[bus_addr] : ~bus_addr;
            end
        end else begin
            bus_ack = 1'b0;
            bus_rdata = 32'd0;
            if (bus_req) stall++;
            else stall = 0;
        end
    end

    // behavioural reference model
    int  m_st = 0, m_rem = 0, r_cnt = 0, m_lim = 1024, m_w = 0;
    logic [31:0] m_src = 0, m_dst = 0, m_data = 0, r_src = 0, r_dst = 0;
    bit  m_si = 0, m_di = 0, r_si = 0, r_di = 0, m_go = 0, m_done = 0, m_err = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_rem = 0; r_cnt = 0; m_lim = 1024; m_w = 0;
            m_src = 0; m_dst = 0; m_data = 0; r_src = 0; r_dst = 0;
            m_si = 0; m_di = 0; r_si = 0; r_di = 0; m_go = 0; m_done = 0; m_err = 0;
        end else begin
            bit busy_now, set_done, set_err;
            busy_now = (m_st != 0) || m_go;
            set_done = 0;
            set_err  = 0;
            case (m_st)
                0: if (m_go) begin
                    if (r_cnt == 0) set_done = 1;
                    else begin
                        m_src = r_src; m_dst = r_dst; m_si = r_si; m_di = r_di;
                        m_rem = r_cnt; m_st = 1; m_w = 0;
                    end
                end
                default: begin
                    if (bus_ack) begin
                        m_w = 0;
                        if (m_st == 1) begin
                            m_data = bus_rdata;
                            m_st = 2;
                        end else begin
                            m_rem--;
                            if (m_si) m_src = m_src + 4;
                            if (m_di) m_dst = m_dst + 4;
                            if (m_rem == 0) begin m_st = 0; set_done = 1; end
                            else m_st = 1;
                        end
                    end else if (m_lim != 0 && m_w == m_lim - 1) begin
                        set_err = 1;
                        m_st = 0;
                    end else m_w++;
                end
            endcase
            m_go = 0;
            if (reg_we) begin
                case (reg_addr)
                    3'd0: r_src = reg_wdata;
                    3'd1: r_dst = reg_wdata;
                    3'd2: r_cnt = int'(reg_wdata[15:0]);
                    3'd3: begin
                        r_si = reg_wdata[1];
                        r_di = reg_wdata[2];
                        if (reg_wdata[0] && !busy_now) m_go = 1;
                    end
                    3'd4: begin
                        if (reg_wdata[1] && !set_done) m_done = 0;
                        if (reg_wdata[2] && !set_err) m_err = 0;
                    end
                    3'd5: m_lim = int'(reg_wdata[15:0]);
                    default: ;
                endcase
            end
            if (set_done) m_done = 1;
            if (set_err) m_err = 1;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk("R3", "bus_req", 32'(bus_req), 32'(m_st != 0));
            if (m_st != 0 && bus_req) begin
                chk("R2", "bus_we", 32'(bus_we), 32'(m_st == 2));
                if (m_st == 2) begin
                    chk("R5", "write address", bus_addr, m_dst);
                    chk("R2", "write data", bus_wdata, m_data);
                end else chk("R4", "read address", bus_addr, m_src);
            end
            chk("R7", "irq", 32'(irq), 32'(m_done));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while ((m_st != 0 || m_go) && n < 5000) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog: actual hung expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base_rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd4, v); chk("R1", "status after reset", v, 32'h0);
        rd(3'd5, v); chk("R1", "limit after reset", v, 32'd1024);
        rd(3'd0, v); chk("R1", "source after reset", v, 32'h0);
        chk("R1", "irq after reset", 32'(irq), 32'h0);

        // R2 R4 R5 R6: four words, both sides stepping, no wait states
        for (int i = 0; i < 4; i++) mem[32'h100 + 4*i] = 32'h1111_0000 + i;
        wr(3'd0, 32'h100); wr(3'd1, 32'h200); wr(3'd2, 32'd4);
        wr(3'd3, 32'h7);
        wait_idle();
        for (int i = 0; i < 4; i++)
            chk("R6", "stepping copy word", mem[32'h200 + 4*i], 32'h1111_0000 + i);
        chk("R2", "write count", 32'(nwr), 32'd4);
        chk("R6", "irq after finish", 32'(irq), 32'h1);
        rd(3'd4, v); chk("R6", "status done", v, 32'h2);
        repeat (5) @(negedge clk);
        chk("R7", "irq held", 32'(irq), 32'h1);
        wr(3'd4, 32'h2);
        chk("R7", "irq cleared", 32'(irq), 32'h0);

        // R4 R6 R8 R11: held peripheral source into 128-word buffer, wait states
        lat = 3; pnext = 32'hC0DE_0000;
        wr(3'd0, PERIPH); wr(3'd1, 32'h1000); wr(3'd2, 32'd128);
        wr(3'd3, 32'h5);
        repeat (20) @(negedge clk);
        rd(3'd4, v); chk("R11", "busy during transfer", v & 32'h1, 32'h1);
        wr(3'd0, 32'h5000); wr(3'd1, 32'h6000); wr(3'd3, 32'h7);
        wait_idle();
        for (int i = 0; i < 128; i++)
            chk("R4", "held source sequence", mem[32'h1000 + 4*i], 32'hC0DE_0000 + i);
        chk("R8", "ignored start left no write", 32'(mem.exists(32'h6000)), 32'h0);
        chk("R8", "total writes", 32'(nwr), 32'd132);
        rd(3'd4, v); chk("R11", "busy gone", v & 32'h1, 32'h0);
        wr(3'd4, 32'h2);

        // R9 zero count
        base_rd = nrd;
        wr(3'd2, 32'd0); wr(3'd3, 32'h7);
        @(negedge clk);
        chk("R9", "done from zero count", 32'(irq), 32'h1);
        chk("R9", "no bus reads", 32'(nrd), 32'(base_rd));
        wr(3'd4, 32'h2);

        // R5 held destination
        lat = 1;
        for (int i = 0; i < 3; i++) mem[32'h300 + 4*i] = 32'hABCD_0000 + i;
        wr(3'd0, 32'h300); wr(3'd1, 32'h400); wr(3'd2, 32'd3);
        wr(3'd3, 32'h3);
        wait_idle();
        chk("R5", "held destination last value", mem[32'h400], 32'hABCD_0002);
        chk("R5", "no stepped write", 32'(mem.exists(32'h404)), 32'h0);
        wr(3'd4, 32'h2);

        // R10 abandoned access
        hang = 1;
        wr(3'd5, 32'd5);
        wr(3'd0, 32'h100); wr(3'd1, 32'h800); wr(3'd2, 32'd2);
        wr(3'd3, 32'h7);
        wait_idle();
        chk("R10", "request cycles before abort", 32'(last_run), 32'd5);
        rd(3'd4, v); chk("R10", "status error only", v, 32'h4);
        chk("R10", "no irq on abort", 32'(irq), 32'h0);
        wr(3'd4, 32'h4);
        rd(3'd4, v); chk("R10", "error cleared", v, 32'h0);
        hang = 0;

        // R3 R10 unbounded stall with limit 0
        lat = 40;
        wr(3'd5, 32'd0);
        wr(3'd1, 32'h700); wr(3'd3, 32'h7);
        wait_idle();
        chk("R3", "long stall word 0", mem[32'h700], 32'h1111_0000);
        chk("R3", "long stall word 1", mem[32'h704], 32'h1111_0001);
        rd(3'd4, v); chk("R10", "no error with limit 0", v, 32'h2);

        summary();
        $finish;
    end
endmodule